// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 16-bit virtual address into a 16-bit physical address using fixed 4 KB pages. The upper four bits of the virtual address select one of sixteen table entries held in flip-flops. Each entry carries a valid flag and a 4-bit physical page number. The lower twelve bits pass straight through as the page offset. No adder is involved: the physical page number is simply placed above the offset.

A programmable table-size limit sets how many virtual pages are legal. A virtual page number equal to or above that limit is refused with a range fault. A page inside the limit whose entry is not marked valid is refused with a separate invalid-entry fault. Software loads entries and the limit through two simple write strobes. Requests come in on a single-cycle request strobe, and the result is registered, so it appears on the next cycle together with a response strobe.

Top module: `page_xlate`

## Requirements
- R1: Reset state. The response strobe is low and the limit is 2. Entry 0 maps to physical page 4 and is valid. Entry 1 maps to physical page 0 and is valid. Entries 2 to 15 are invalid.
- R2: For a translated request, bits 11:0 of the response address equal bits 11:0 of the request address.
- R3: For a translated request, bits 15:12 of the response address equal the physical page number stored in the entry indexed by request address bits 15:12. In this case the fault code is 0.
- R4: If the virtual page number is greater than or equal to the limit, the response carries fault code 1 (range) and an address of 0.
- R5: If the virtual page number is below the limit but the entry's valid flag is 0, the response carries fault code 2 (invalid) and an address of 0.
- R6: When both R4 and R5 apply, the range fault (code 1) is reported.
- R7: The response strobe rises exactly one cycle after each request strobe and at no other time. While the response strobe is low, the fault code and the address are 0.
- R8: An entry write (`pte_we` with `pte_idx`, `pte_ppn`, `pte_valid`) changes only the addressed entry. It is seen by requests made in later cycles. A request made in the same cycle as the write sees the old contents.
- R9: A limit write (`lim_we`, `lim_val`) takes effect for requests in later cycles. A limit of 0 faults every page. A limit of 16 or more allows every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pte_we | input | 1 | Entry write strobe |
| pte_idx | input | 4 | Entry index to write |
| pte_ppn | input | 4 | Physical page number to store |
| pte_valid | input | 1 | Valid flag to store |
| lim_we | input | 1 | Limit write strobe |
| lim_val | input | 5 | New table-size limit |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_pa | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 range fault, 2 invalid entry |

## Verification
A corrupted entry shows up on the very next request to that page, either as a wrong upper address nibble or as the wrong fault code. A wrong limit register moves the boundary between translated and range-faulted pages, so it shows one cycle after any request near the limit. The bench walks every page under every limit from 0 to 16, with a pattern that mixes valid and invalid entries. Each such fault therefore appears at the ports within one request of the first affected page.

// File: rtl/pgx_pkg.sv
// Package: shared widths, the entry type, fault codes and reset mapping.
// Assumes a single page size fixed by OFF_W.
package pgx_pkg;
    localparam int VA_W   = 16;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 4;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int N_ENT  = 1 << VPN_W;
    localparam int LIM_W  = VPN_W + 1;
    localparam int LIM_RST = 2;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_RANGE = 2'd1,
        FLT_INVAL = 2'd2
    } fault_t;

    // Reset contents: page 0 -> 4, page 1 -> 0, the rest invalid.
    function automatic pte_t reset_entry(input int idx);
        pte_t e;
        e.valid = (idx < 2);
        e.ppn   = (idx == 0) ? PPN_W'(4) : '0;
        return e;
    endfunction
endpackage

// File: rtl/pt_store.sv
// Module: page table storage. Holds N_ENT entries in flip-flops with one
// write port and one combinational read port. Assumes rd_idx is stable
// around the clock edge; writes appear on the read port next cycle.
module pt_store
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VPN_W-1:0] wr_idx,
    input  pte_t             wr_entry,
    input  logic [VPN_W-1:0] rd_idx,
    output pte_t             rd_entry
);
    pte_t ents [N_ENT];

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_ent
            // Purpose: reset or overwrite one entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ents[g] <= reset_entry(g);
                else if (we && wr_idx == VPN_W'(g))
                    ents[g] <= wr_entry;
            end
        end
    endgenerate

    // Purpose: read the indexed entry.
    always_comb rd_entry = ents[rd_idx];

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ents[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/pt_limit.sv
// Module: the table-size limit register. Resets to LIM_RST and loads on
// a strobe. Assumes any 5-bit value is legal; values above N_ENT allow all.
module pt_limit
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LIM_W-1:0] wval,
    output logic [LIM_W-1:0] lim
);
    // Purpose: hold the current limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim <= LIM_W'(LIM_RST);
        else if (we)
            lim <= wval;
    end

    assert_limit_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> lim == $past(wval));
endmodule

// File: rtl/pt_lookup.sv
// Module: legality check and result register. Compares the page number
// with the limit, checks the entry flag, and registers address and fault.
// Assumes entry and limit are the values before this edge.
module pt_lookup
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  pte_t             ent,
    input  logic [LIM_W-1:0] lim,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic             out_of_range;
    fault_t           code;

    // Purpose: split the address and decide the fault code.
    always_comb begin
        vpn          = req_va[VA_W-1:OFF_W];
        off          = req_va[OFF_W-1:0];
        out_of_range = ({1'b0, vpn} >= lim);
        if (out_of_range)      code = FLT_RANGE;
        else if (!ent.valid)   code = FLT_INVAL;
        else                   code = FLT_NONE;
    end

    // Purpose: register the response, zeroed when idle or faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_pa    <= (req_valid && code == FLT_NONE) ? {ent.ppn, off} : '0;
            rsp_fault <= req_valid ? code : FLT_NONE;
        end
    end

    assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 2'd0 && rsp_pa == '0));
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && code == FLT_NONE) |=> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));
    assert_range_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && {1'b0, req_va[VA_W-1:OFF_W]} >= lim) |=> rsp_fault == 2'd1);
    assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> rsp_pa == '0);
    assert_invalid_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && {1'b0, req_va[VA_W-1:OFF_W]} < lim && !ent.valid) |=> rsp_fault == 2'd2);
endmodule

// File: rtl/page_xlate.sv
// Module: top of the page translator. Wires the table, the limit register
// and the lookup stage. Assumes one request per cycle at most; result is
// one cycle later.
module page_xlate
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pte_we,
    input  logic [VPN_W-1:0] pte_idx,
    input  logic [PPN_W-1:0] pte_ppn,
    input  logic             pte_valid,
    input  logic             lim_we,
    input  logic [LIM_W-1:0] lim_val,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault
);
    pte_t             wr_ent;
    pte_t             rd_ent;
    logic [LIM_W-1:0] lim;

    // Purpose: pack the write data into an entry.
    always_comb begin
        wr_ent.valid = pte_valid;
        wr_ent.ppn   = pte_ppn;
    end

    pt_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (pte_we),
        .wr_idx   (pte_idx),
        .wr_entry (wr_ent),
        .rd_idx   (req_va[VA_W-1:OFF_W]),
        .rd_entry (rd_ent)
    );

    pt_limit u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lim_we),
        .wval  (lim_val),
        .lim   (lim)
    );

    pt_lookup u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_va    (req_va),
        .ent       (rd_ent),
        .lim       (lim),
        .rsp_valid (rsp_valid),
        .rsp_pa    (rsp_pa),
        .rsp_fault (rsp_fault)
    );

    assert_translate_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && {1'b0, req_va[VA_W-1:OFF_W]} < lim && rd_ent.valid)
        |=> (rsp_fault == 2'd0 && rsp_pa[PA_W-1:OFF_W] == $past(rd_ent.ppn)));
endmodule

// File: tb/page_xlate_tb.sv
// Bench: sweeps every page under every limit with a bench-side model.
module page_xlate_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pte_we = 1'b0;
    logic [3:0]  pte_idx = '0;
    logic [3:0]  pte_ppn = '0;
    logic        pte_valid = 1'b0;
    logic        lim_we = 1'b0;
    logic [4:0]  lim_val = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_va = '0;
    logic        rsp_valid;
    logic [15:0] rsp_pa;
    logic [1:0]  rsp_fault;

    int total = 0;
    int bad = 0;
    logic [3:0] m_ppn [16];
    logic       m_val [16];
    int         m_lim;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .pte_we(pte_we), .pte_idx(pte_idx),
        .pte_ppn(pte_ppn), .pte_valid(pte_valid), .lim_we(lim_we),
        .lim_val(lim_val), .req_valid(req_valid), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_pte(input int idx, input int ppn, input logic v);
        pte_we = 1'b1; pte_idx = 4'(idx); pte_ppn = 4'(ppn); pte_valid = v;
        @(negedge clk);
        pte_we = 1'b0;
        m_ppn[idx] = 4'(ppn); m_val[idx] = v;
    endtask

    task automatic wr_lim(input int l);
        lim_we = 1'b1; lim_val = 5'(l);
        @(negedge clk);
        lim_we = 1'b0;
        m_lim = l;
    endtask

    // Issue one request; check response one edge later against the model.
    task automatic xlate(input logic [15:0] va, input string tag);
        int vpn;
        logic [1:0]  ef;
        logic [15:0] ep;
        vpn = int'(va[15:12]);
        if (vpn >= m_lim)      begin ef = 2'd1; ep = 16'h0; end
        else if (!m_val[vpn])  begin ef = 2'd2; ep = 16'h0; end
        else                   begin ef = 2'd0; ep = {m_ppn[vpn], va[11:0]}; end
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R7 strobe"}, 32'(rsp_valid), 32'd1);
        check({tag, " R4 R5 R6 fault"}, 32'(rsp_fault), 32'(ef));
        check({tag, " R2 R3 address"}, 32'(rsp_pa), 32'(ep));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_val[i] = (i < 2); m_ppn[i] = (i == 0) ? 4'd4 : 4'd0;
        end
        m_lim = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        xlate(16'h0123, "R1 page0");
        xlate(16'h1ABC, "R1 page1");
        xlate(16'h2000, "R1 page2 range");
        wr_lim(16);
        for (int v = 0; v < 16; v++) xlate({4'(v), 12'hFFF}, "R1 sweep");
        // R7: idle cycle after a response
        @(negedge clk);
        check("R7 idle strobe", 32'(rsp_valid), 32'd0);
        check("R7 idle pa", 32'(rsp_pa), 32'd0);
        check("R7 idle fault", 32'(rsp_fault), 32'd0);
        // R8: program a mixed table
        for (int i = 0; i < 16; i++) wr_pte(i, (i * 7 + 3) % 16, (i % 3) != 0);
        // R9 + R4/R5/R6: every limit and every page
        for (int l = 0; l <= 17; l++) begin
            wr_lim(l);
            for (int v = 0; v < 16; v++)
                xlate({4'(v), 12'((v * 273 + l * 5) % 4096)}, "R9 sweep");
        end
        // R8: same-cycle write sees old contents, later request sees new
        wr_lim(16);
        pte_we = 1'b1; pte_idx = 4'd5; pte_ppn = 4'd9; pte_valid = 1'b1;
        req_valid = 1'b1; req_va = 16'h5321;
        @(negedge clk);
        pte_we = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle old fault", 32'(rsp_fault), 32'(m_val[5] ? 0 : 2));
        check("R8 same-cycle old pa", 32'(rsp_pa), m_val[5] ? 32'({m_ppn[5], 12'h321}) : 32'd0);
        m_ppn[5] = 4'd9; m_val[5] = 1'b1;
        xlate(16'h5321, "R8 new");
        xlate(16'h6321, "R8 neighbour");
        // R8: invalidate an entry
        wr_pte(4, 4'd2, 1'b0);
        xlate(16'h4777, "R8 invalidate");
        // back-to-back requests
        req_valid = 1'b1; req_va = 16'h5001;
        @(negedge clk);
        req_va = 16'h4002;
        check("R7 b2b first", 32'(rsp_pa), 32'h9001);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 b2b second fault", 32'(rsp_fault), 32'd2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule